// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Shadowed Duty Registers

This block drives a small set of PWM outputs, all timed by one shared period counter. The counter climbs from 0 to a programmable top value and then restarts. Each channel is shaped by two compare values. The rise compare sets where the high phase starts, and the fall compare sets where it ends. The difference between the two is the channel's duty.

A channel can be built with a second, staged copy of its two compare values. This choice is a per-channel parameter. On such a channel, software can turn on a per-channel synchronous bit. While that bit is on, writes go only into the staged copy. The staged copy moves into the live copy on the cycle where the counter wraps, so a period that has already started is never disturbed. Without the bit, or on a channel built without the staged copy, a write changes the live value on the next edge. The output may then glitch.

Each channel also has a low-ripple option. It replaces the waveform with a stream of single-cycle pulses whose density equals the duty. Configuration goes through a plain write strobe with a register kind, a channel index and a data word.

Top module: `mpwm_top`

## Requirements
- R1: After reset every output is low, the top value is 0, all compare values are 0, and the synchronous and low-ripple bit masks are all 0.
- R2: In normal mode a channel output is registered. It is high in the cycle after the counter holds a value c with rise <= c < fall. The high time per period is therefore fall - rise when rise < fall <= top + 1.
- R3: When rise >= fall and low-ripple mode is off, the channel output stays low.
- R4: The counter runs 0, 1, ..., top and then returns to 0, so every period lasts exactly top + 1 cycles.
- R5: A write to a compare value of a channel whose synchronous mode is not in effect changes its live value on the next clock edge, in the middle of a period.
- R6: In synchronous mode, writes to a channel go only to its staged values. Both staged values are copied to the live values on the counter's wrap cycle, so the period in progress keeps its old waveform and the next one uses the new values.
- R7: A synchronous bit has no effect on a channel built without staged registers (parameter bit 0); such a channel always behaves as in R5.
- R8: Because the synchronous mask resets to 0, a shadowed channel updates immediately until software sets its bit.
- R9: In low-ripple mode a first-order accumulator adds the duty modulo top + 1 every cycle. The output is high, registered, on each carry. Any top + 1 consecutive output cycles then hold exactly duty high cycles (duty is fall - rise, or 0 if rise >= fall).
- R10: In low-ripple mode, when 2 * duty <= top + 1, no two consecutive output cycles are high.
- R11: Register kinds on `wr_kind` are decoded as follows: 0 is the top value (data[CW-1:0]), 1 is rise, 2 is fall (both for channel `wr_ch`), 3 is the synchronous mask (data[NCH-1:0]) and 4 is the low-ripple mask (data[NCH-1:0]). Kinds 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind being written (see R11) |
| wr_ch | input | CHW = $clog2(NCH) | Channel index for compare writes |
| wr_data | input | DW = max(CW, NCH) | Write data |
| pwm_out | output | NCH | Channel outputs |

## Verification
The main waveform is driven with a table of top and compare settings. The table covers an ordinary window inside the period and a full-period high phase. It also has rise equal to fall and rise above fall, which separate a correct empty-window rule from an off-by-one compare. Low-ripple entries at sparse, moderate and full density check the exact high count per top + 1 cycles, and also check that pulses stay isolated, which a plain PWM would fail. The mid-period write pattern is run twice, once with the synchronous mask clear and once with it set. Each run covers both a shadowed channel and an unshadowed one. Together these tell immediate, deferred and ignored-mode behaviour apart within the same period.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;
  typedef enum logic [2:0] {
    KIND_TOP   = 3'd0,
    KIND_RISE  = 3'd1,
    KIND_FALL  = 3'd2,
    KIND_SYNC  = 3'd3,
    KIND_LRIP  = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/mpwm_period_ctr.sv
`timescale 1ns/1ps
module mpwm_period_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  // A lowered top value mid-period also ends the period at once.
  assign wrap = (cnt >= top);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mpwm_chan_regs.sv
`timescale 1ns/1ps
module mpwm_chan_regs #(
  parameter int CW         = 8,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic          sync_en,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] act_rise,
  output logic [CW-1:0] act_fall
);
  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [CW-1:0] stg_rise, stg_fall;
      logic          load_now;
      assign load_now = sync_en && wrap;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stg_rise <= '0;
          stg_fall <= '0;
        end else begin
          if (wr_rise) stg_rise <= wr_val;
          if (wr_fall) stg_fall <= wr_val;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_rise <= '0;
          act_fall <= '0;
        end else if (load_now) begin
          act_rise <= stg_rise;
          act_fall <= stg_fall;
        end else if (!sync_en) begin
          if (wr_rise) act_rise <= wr_val;
          if (wr_fall) act_fall <= wr_val;
        end
      end
    end else begin : g_direct
      logic unused_mode;
      assign unused_mode = wrap ^ sync_en;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_rise <= '0;
          act_fall <= '0;
        end else begin
          if (wr_rise) act_rise <= wr_val;
          if (wr_fall) act_fall <= wr_val;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mpwm_chan_out.sv
`timescale 1ns/1ps
module mpwm_chan_out #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] act_rise,
  input  logic [CW-1:0] act_fall,
  input  logic          lowrip,
  output logic          out
);
  localparam int AW = CW + 1;

  function automatic logic in_window(input logic [CW-1:0] c,
                                     input logic [CW-1:0] r,
                                     input logic [CW-1:0] f);
    return (c >= r) && (c < f);
  endfunction

  function automatic logic [CW-1:0] duty_of(input logic [CW-1:0] r,
                                            input logic [CW-1:0] f);
    return (f > r) ? (f - r) : '0;
  endfunction

  logic [AW-1:0] acc, modulus, base, sum, acc_nxt;
  logic          level, carry;

  assign level   = in_window(cnt, act_rise, act_fall);
  assign modulus = {1'b0, top} + 1'b1;
  assign base    = (acc >= modulus) ? '0 : acc;
  assign sum     = base + {1'b0, duty_of(act_rise, act_fall)};
  assign carry   = (sum >= modulus);
  assign acc_nxt = carry ? (sum - modulus) : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      out <= 1'b0;
    end else begin
      acc <= acc_nxt;
      out <= lowrip ? carry : level;
    end
  end
endmodule

// File: rtl/mpwm_top.sv
`timescale 1ns/1ps
module mpwm_top #(
  parameter int             NCH         = 4,
  parameter int             CW          = 8,
  parameter logic [NCH-1:0] SHADOW_MASK = {NCH{1'b1}},
  localparam int            CHW         = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int            DW          = (CW > NCH) ? CW : NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_kind,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_out
);
  import mpwm_pkg::*;

  logic [CW-1:0]           top_q;
  logic [NCH-1:0]          sync_q, lrip_q, sync_eff;
  logic [CW-1:0]           cnt;
  logic                    wrap;
  logic [NCH-1:0][CW-1:0]  act_rise, act_fall;
  logic                    wr_rise_any, wr_fall_any;

  assign wr_rise_any = wr_en && (wr_kind == KIND_RISE);
  assign wr_fall_any = wr_en && (wr_kind == KIND_FALL);
  assign sync_eff    = sync_q & SHADOW_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q  <= '0;
      sync_q <= '0;
      lrip_q <= '0;
    end else if (wr_en) begin
      case (wr_kind)
        KIND_TOP:  top_q  <= wr_data[CW-1:0];
        KIND_SYNC: sync_q <= wr_data[NCH-1:0];
        KIND_LRIP: lrip_q <= wr_data[NCH-1:0];
        default:   ;
      endcase
    end
  end

  mpwm_period_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .top(top_q), .cnt(cnt), .wrap(wrap)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit;
      assign hit = (wr_ch == CHW'(i));

      mpwm_chan_regs #(.CW(CW), .HAS_SHADOW(SHADOW_MASK[i])) u_regs (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .sync_en(sync_eff[i]),
        .wr_rise(wr_rise_any && hit), .wr_fall(wr_fall_any && hit),
        .wr_val(wr_data[CW-1:0]),
        .act_rise(act_rise[i]), .act_fall(act_fall[i])
      );

      mpwm_chan_out #(.CW(CW)) u_out (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .top(top_q),
        .act_rise(act_rise[i]), .act_fall(act_fall[i]),
        .lowrip(lrip_q[i]), .out(pwm_out[i])
      );
    end
  endgenerate
endmodule

// File: rtl/mpwm_checker.sv
`timescale 1ns/1ps
module mpwm_checker #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int CHW = 2,
  parameter int DW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [2:0]             wr_kind,
  input logic [CHW-1:0]         wr_ch,
  input logic [DW-1:0]          wr_data,
  input logic [CW-1:0]          cnt,
  input logic                   wrap,
  input logic [NCH-1:0]         sync_eff,
  input logic [NCH-1:0]         lrip_q,
  input logic [NCH-1:0][CW-1:0] act_rise,
  input logic [NCH-1:0][CW-1:0] act_fall,
  input logic [NCH-1:0]         pwm_out
);
  assert_wrap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt == $past(cnt) + 1'b1));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_eff[i] && !wrap) |=> ($stable(act_rise[i]) && $stable(act_fall[i])));

      assert_empty_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lrip_q[i] && (act_rise[i] >= act_fall[i])) |=> !pwm_out[i]);

      assert_immediate_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 3'd1 && wr_ch == CHW'(i) && !sync_eff[i])
          |=> (act_rise[i] == $past(wr_data[CW-1:0])));
    end
  endgenerate
endmodule

bind mpwm_top mpwm_checker #(.NCH(NCH), .CW(CW), .CHW(CHW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_ch(wr_ch),
  .wr_data(wr_data), .cnt(cnt), .wrap(wrap), .sync_eff(sync_eff),
  .lrip_q(lrip_q), .act_rise(act_rise), .act_fall(act_fall), .pwm_out(pwm_out)
);

// File: tb/mpwm_top_bench.sv
`timescale 1ns/1ps
module mpwm_top_bench;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_kind = '0;
  logic [1:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mpwm_top #(.NCH(NCH), .CW(CW), .SHADOW_MASK(4'b0111)) u_mpwm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_ch(wr_ch), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  // {top, rise, fall, lowrip}
  localparam logic [31:0] VEC [8] = '{
    {8'd9,  8'd2,  8'd5,  8'd0},
    {8'd15, 8'd0,  8'd16, 8'd0},
    {8'd15, 8'd5,  8'd5,  8'd0},
    {8'd20, 8'd10, 8'd3,  8'd0},
    {8'd7,  8'd1,  8'd4,  8'd1},
    {8'd99, 8'd10, 8'd47, 8'd1},
    {8'd12, 8'd0,  8'd13, 8'd1},
    {8'd63, 8'd3,  8'd4,  8'd1}
  };

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input logic [1:0] ch, input logic [7:0] d);
    wr_en = 1'b1; wr_kind = k; wr_ch = ch; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_mark();
    logic prev;
    prev = pwm_out[0];
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (pwm_out[0] && !prev) return;
      prev = pwm_out[0];
    end
  endtask

  task automatic count_all(input int n, output int hi [4], output bit dbl [4]);
    logic [3:0] prev;
    prev = '0;
    for (int c = 0; c < 4; c++) begin hi[c] = 0; dbl[c] = 1'b0; end
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < 4; c++) begin
        if (pwm_out[c]) begin
          hi[c]++;
          if (prev[c]) dbl[c] = 1'b1;
        end
      end
      prev = pwm_out;
      @(negedge clk);
    end
  endtask

  // Mid-period writes: ch1 (shadowed) and ch3 (no shadow), top = 9.
  task automatic run_mid(input string tag, input int e1a, input int e1b,
                         input int e3a, input int e3b);
    int  w1 [4];
    int  w2 [4];
    bit  d1 [4];
    bit  d2 [4];
    wr(3'd1, 2'd1, 8'd2); wr(3'd2, 2'd1, 8'd5);
    wr(3'd1, 2'd3, 8'd2); wr(3'd2, 2'd3, 8'd5);
    repeat (30) @(negedge clk);
    wait_mark();
    fork
      begin count_all(10, w1, d1); count_all(10, w2, d2); end
      begin wr(3'd1, 2'd1, 8'd4); wr(3'd2, 2'd1, 8'd9); wr(3'd2, 2'd3, 8'd8); end
    join
    check({tag, " ch1 current period"}, w1[1], e1a);
    check({tag, " ch1 next period"},    w2[1], e1b);
    check({tag, " ch3 current period"}, w1[3], e3a);
    check({tag, " ch3 next period"},    w2[3], e3b);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  hi [4];
    bit  dbl [4];
    int  per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all outputs low after reset
    count_all(6, hi, dbl);
    check("R1 outputs low after reset", hi[0] + hi[1] + hi[2] + hi[3], 0);

    wr(3'd0, 2'd0, 8'd9);
    wr(3'd1, 2'd0, 8'd0); wr(3'd2, 2'd0, 8'd1);

    // R8 / R5: sync mask still 0, so ch1 updates mid-period
    run_mid("R8 R5 reset-mask", 5, 5, 6, 6);

    // R2 R3 R4 R9 R10 on ch2 from the vector table
    foreach (VEC[v]) begin
      int tp, rs, fl, lr, dty;
      tp = int'(VEC[v][31:24]); rs = int'(VEC[v][23:16]);
      fl = int'(VEC[v][15:8]);  lr = int'(VEC[v][7:0]);
      dty = (fl > rs) ? fl - rs : 0;
      wr(3'd0, 2'd0, 8'(tp));
      wr(3'd1, 2'd2, 8'(rs));
      wr(3'd2, 2'd2, 8'(fl));
      wr(3'd4, 2'd0, (lr != 0) ? 8'h04 : 8'h00);
      repeat (3 * (tp + 1) + 4) @(negedge clk);
      count_all(tp + 1, hi, dbl);
      if (lr != 0) begin
        check($sformatf("R9 low-ripple density vec %0d", v), hi[2], dty);
        if (2 * dty <= tp + 1)
          check($sformatf("R10 isolated pulses vec %0d", v), int'(dbl[2]), 0);
      end else if (dty == 0) begin
        check($sformatf("R3 empty window low vec %0d", v), hi[2], 0);
      end else begin
        check($sformatf("R2 high time vec %0d", v), hi[2], dty);
      end
      wait_mark();
      per = 0;
      begin
        logic prev;
        prev = pwm_out[0];
        for (int k = 0; k < 1000; k++) begin
          @(negedge clk);
          per++;
          if (pwm_out[0] && !prev) break;
          prev = pwm_out[0];
        end
      end
      check($sformatf("R4 period length vec %0d", v), per, tp + 1);
    end

    wr(3'd4, 2'd0, 8'h00);
    wr(3'd0, 2'd0, 8'd9);
    wr(3'd3, 2'd0, 8'h0A);
    // R6 on ch1 (deferred), R7 on ch3 (sync bit ignored)
    run_mid("R6 R7 sync-mask", 3, 5, 6, 6);

    // R11: kinds 5..7 change nothing
    wr(3'd5, 2'd1, 8'd0);
    wr(3'd6, 2'd1, 8'd0);
    wr(3'd7, 2'd1, 8'd0);
    repeat (25) @(negedge clk);
    count_all(10, hi, dbl);
    check("R11 unused kinds leave ch1 duty", hi[1], 5);
    check("R11 unused kinds leave marker", hi[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule